// File: doc/BRIEF.md
# Clustered Translation Lookaside Buffer

This block is a small fully associative translation cache. Each of its entries covers an aligned group of eight virtual pages. Every page in the group maps into one aligned cluster of eight physical frames. The entry stores one base virtual page number and one base physical page number. Each of its eight slots then holds its own valid bit and its own three low physical-page bits. Because each slot carries its own low bits, one entry can describe a group with gaps (holes), and a group whose frames are scattered in any order inside the cluster. It does not need a strictly contiguous run of frames.

A lookup presents a virtual page number. The hit flag and the translated physical page number come back in the same cycle. An external agent builds a complete entry and writes it in with a fill strobe. The block itself picks the slot that the fill lands in. A fill whose base matches a live entry reuses that entry. Otherwise the fill takes the lowest-numbered empty entry. When no entry is empty, a rotating victim pointer picks the entry to replace. A flush input empties the whole buffer in one clock.

Top module: `cluster_tlb`

## Requirements
- R1: The lookup hits when a valid entry's base equals lookupVpn[VPN_W-1:3] and the slot selected by lookupVpn[2:0] is valid. On a hit, ppn equals {base PPN, low bits of that slot}. Slot i's valid bit is fillSubValid[i], and slot i's low bits are fillSubPpn[3*i+2:3*i].
- R2: Slot low bits may form any permutation or repetition inside the cluster. A hit returns the stored value unchanged, whatever the slot index.
- R3: A lookup that matches a base but selects an invalid slot (a hole) is a miss: hit is 0 and ppn is 0.
- R4: A lookup that matches no valid base is a miss: hit is 0 and ppn is 0.
- R5: Lookup is combinational on the current contents. A fill becomes visible only after the rising clock edge that samples fillEn.
- R6: A fill whose base equals that of a valid entry overwrites that entry in place. No other entry is lost, and the victim pointer does not move.
- R7: A fill that matches no valid base, while some entry is invalid, is written into the lowest-indexed invalid entry.
- R8: A fill that matches no valid base, while all entries are valid, replaces the entry at the victim pointer. The pointer then advances by one and wraps after NUM_ENTRIES-1.
- R9: Flush invalidates every entry on the next edge and returns the victim pointer to 0. A flush overrides a fill in the same cycle, and that fill is discarded.
- R10: After reset, all entries are invalid, every lookup misses, and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| hit | output | 1 | Translation found |
| ppn | output | PPN_W | Translated physical page number, zero on a miss |
| fillEn | input | 1 | Write the presented entry on this edge |
| fillBaseVpn | input | VPN_W-3 | Base virtual page number of the new entry |
| fillBasePpn | input | PPN_W-3 | Base physical page number of the new entry |
| fillSubValid | input | 8 | Per-slot valid bits |
| fillSubPpn | input | 24 | Per-slot low physical bits, three per slot |
| flush | input | 1 | Invalidate all entries |

## Verification
Corrupt stored low bits or a misrouted slot select show up as a wrong ppn on the very next lookup of that page. The sweep visits every slot of every entry, so such a fault appears within one pass. A faulty victim choice is invisible until it matters. It surfaces only as a miss on a page that should have survived a later fill, or as a hit on a page that should have been evicted. For this reason the bench fills past capacity and then probes the survivors. A pointer that moves on an overwrite, or that fails to reset on a flush, is exposed one replacement later by the wrong entry disappearing.

// File: rtl/ctlb_pkg.sv
package ctlb_pkg;
  // Strobes from the control to the entry store.
  typedef struct packed {
    logic wrEn;
    logic flushAll;
  } ctlbStrobe_t;
endpackage

// File: rtl/ctlb_store.sv
module ctlb_store
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 36,
  parameter int PPN_W       = 28,
  parameter int CL_LOG2     = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ctlbStrobe_t                        strobe,
  input  logic [$clog2(NUM_ENTRIES)-1:0]     wrIdx,
  input  logic [VPN_W-CL_LOG2-1:0]           fillBaseVpn,
  input  logic [PPN_W-CL_LOG2-1:0]           fillBasePpn,
  input  logic [(1<<CL_LOG2)-1:0]            fillSubValid,
  input  logic [(1<<CL_LOG2)*CL_LOG2-1:0]    fillSubPpn,
  input  logic [VPN_W-1:0]                   lookupVpn,
  output logic [NUM_ENTRIES-1:0]             entryValid,
  output logic [NUM_ENTRIES-1:0]             fillMatch,
  output logic                               hit,
  output logic [PPN_W-1:0]                   ppn
);
  localparam int SUBS = 1 << CL_LOG2;
  localparam int BV_W = VPN_W - CL_LOG2;
  localparam int BP_W = PPN_W - CL_LOG2;

  logic [NUM_ENTRIES-1:0] validQ;
  logic [BV_W-1:0]        baseVpnQ  [NUM_ENTRIES];
  logic [BP_W-1:0]        basePpnQ  [NUM_ENTRIES];
  logic [SUBS-1:0]        subValidQ [NUM_ENTRIES];
  logic [SUBS*CL_LOG2-1:0] subPpnQ  [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] subHit;
  logic [PPN_W-1:0]       entryPpn [NUM_ENTRIES];
  logic [CL_LOG2-1:0]     offset;

  assign offset     = lookupVpn[CL_LOG2-1:0];
  assign entryValid = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)                validQ         <= '0;
    else if (strobe.flushAll) validQ         <= '0;
    else if (strobe.wrEn)     validQ[wrIdx]  <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn && !strobe.flushAll) begin
      baseVpnQ[wrIdx]  <= fillBaseVpn;
      basePpnQ[wrIdx]  <= fillBasePpn;
      subValidQ[wrIdx] <= fillSubValid;
      subPpnQ[wrIdx]   <= fillSubPpn;
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic baseHit;
    assign baseHit      = validQ[e] && (baseVpnQ[e] == lookupVpn[VPN_W-1:CL_LOG2]);
    assign subHit[e]    = baseHit && subValidQ[e][offset];
    assign entryPpn[e]  = subHit[e] ? {basePpnQ[e], subPpnQ[e][offset*CL_LOG2 +: CL_LOG2]}
                                    : '0;
    assign fillMatch[e] = validQ[e] && (baseVpnQ[e] == fillBaseVpn);
  end

  always_comb begin
    ppn = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) ppn = ppn | entryPpn[e];
    hit = |subHit;
  end

  // R1: no two entries may claim the same page
  a_r1_single_hit: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(subHit));
  // R3/R4: a miss never leaks a stale translation
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (ppn == '0));
  // R9: flush empties the store on the next edge
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushAll |=> (validQ == '0) && !hit);
endmodule

// File: rtl/ctlb_ctrl.sv
module ctlb_ctrl
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           fillEn,
  input  logic                           flush,
  input  logic [NUM_ENTRIES-1:0]         entryValid,
  input  logic [NUM_ENTRIES-1:0]         fillMatch,
  output ctlbStrobe_t                    strobe,
  output logic [$clog2(NUM_ENTRIES)-1:0] wrIdx
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [IDX_W-1:0] rrPtr, matchIdx, freeIdx;
  logic             anyMatch, anyFree, useRr;

  always_comb begin
    matchIdx = '0;
    freeIdx  = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (fillMatch[e])   matchIdx = IDX_W'(e);
      if (!entryValid[e]) freeIdx  = IDX_W'(e);
    end
    anyMatch = |fillMatch;
    anyFree  = !(&entryValid);
    useRr    = !anyMatch && !anyFree;
    wrIdx    = anyMatch ? matchIdx : (anyFree ? freeIdx : rrPtr);
    strobe.flushAll = flush;
    strobe.wrEn     = fillEn && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush)             rrPtr <= '0;
    else if (strobe.wrEn && useRr)  rrPtr <= (rrPtr == LAST) ? '0 : rrPtr + 1'b1;
  end

  // R6: an existing base is the target of its own refill
  a_r6_match_target: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush && (|fillMatch)) |-> fillMatch[wrIdx]);
  // R6: duplicates of one base never exist
  a_r6_no_duplicate: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fillMatch));
  // R7: a new base never displaces a live entry while space remains
  a_r7_free_target: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush && !(|fillMatch) && !(&entryValid)) |-> !entryValid[wrIdx]);
  // R8: the pointer holds still unless it chose the victim
  a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!flush && !(fillEn && (&entryValid) && !(|fillMatch))) |=> $stable(rrPtr));
endmodule

// File: rtl/cluster_tlb.sv
module cluster_tlb
  import ctlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int VPN_W       = 36,
  parameter int PPN_W       = 28
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [VPN_W-1:0]   lookupVpn,
  output logic               hit,
  output logic [PPN_W-1:0]   ppn,
  input  logic               fillEn,
  input  logic [VPN_W-4:0]   fillBaseVpn,
  input  logic [PPN_W-4:0]   fillBasePpn,
  input  logic [7:0]         fillSubValid,
  input  logic [23:0]        fillSubPpn,
  input  logic               flush
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  ctlbStrobe_t             strobe;
  logic [IDX_W-1:0]        wrIdx;
  logic [NUM_ENTRIES-1:0]  entryValid, fillMatch;

  ctlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .fillEn(fillEn), .flush(flush),
    .entryValid(entryValid), .fillMatch(fillMatch),
    .strobe(strobe), .wrIdx(wrIdx)
  );

  ctlb_store #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .CL_LOG2(3)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx),
    .fillBaseVpn(fillBaseVpn), .fillBasePpn(fillBasePpn),
    .fillSubValid(fillSubValid), .fillSubPpn(fillSubPpn),
    .lookupVpn(lookupVpn), .entryValid(entryValid), .fillMatch(fillMatch),
    .hit(hit), .ppn(ppn)
  );
endmodule

// File: tb/tb_cluster_tlb.sv
module tb_cluster_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [35:0] lookupVpn = '0;
  logic        hit;
  logic [27:0] ppn;
  logic        fillEn = 1'b0;
  logic [32:0] fillBaseVpn = '0;
  logic [24:0] fillBasePpn = '0;
  logic [7:0]  fillSubValid = '0;
  logic [23:0] fillSubPpn = '0;
  logic        flush = 1'b0;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cluster_tlb dut (
    .clk(clk), .rstN(rstN), .lookupVpn(lookupVpn), .hit(hit), .ppn(ppn),
    .fillEn(fillEn), .fillBaseVpn(fillBaseVpn), .fillBasePpn(fillBasePpn),
    .fillSubValid(fillSubValid), .fillSubPpn(fillSubPpn), .flush(flush)
  );

  function automatic logic [32:0] baseV(int k); return 33'(k * 1000 + 7); endfunction
  function automatic logic [24:0] baseP(int k); return 25'(k * 37 + 5); endfunction
  function automatic logic [2:0]  lowP(int k, int i); return 3'((3 * i + k) % 8); endfunction
  function automatic bit isHole(int k, int i); return i == (k % 8); endfunction

  task automatic drive(int k);
    fillBaseVpn = baseV(k);
    fillBasePpn = baseP(k);
    for (int i = 0; i < 8; i++) begin
      fillSubValid[i]       = !isHole(k, i);
      fillSubPpn[3*i +: 3]  = lowP(k, i);
    end
  endtask

  task automatic fill(int k);
    @(negedge clk);
    drive(k);
    fillEn = 1'b1;
    @(negedge clk);
    fillEn = 1'b0;
  endtask

  task automatic check(string req, logic [35:0] vpn, bit expHit, logic [27:0] expPpn);
    lookupVpn = vpn;
    #1;
    tests++;
    if (hit !== expHit || ppn !== expPpn) begin
      fails++;
      $display("FAIL %s vpn=%h hit=%0b ppn=%h expected hit=%0b ppn=%h",
               req, vpn, hit, ppn, expHit, expPpn);
    end
  endtask

  // Check an entry generated from index k at offset i, present or evicted.
  task automatic probe(string req, int k, int i, bit present);
    bit h;
    h = present && !isHole(k, i);
    check(req, {baseV(k), 3'(i)}, h, h ? {baseP(k), lowP(k, i)} : 28'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: empty after reset
    check("R10", {baseV(0), 3'd1}, 1'b0, 28'd0);
    check("R10", 36'd0, 1'b0, 28'd0);

    // R5: fill invisible before its edge
    @(negedge clk);
    drive(0);
    fillEn = 1'b1;
    check("R5", {baseV(0), 3'd1}, 1'b0, 28'd0);
    @(negedge clk);
    fillEn = 1'b0;
    check("R5", {baseV(0), 3'd1}, 1'b1, {baseP(0), lowP(0, 1)});

    for (int k = 1; k < N; k++) fill(k);
    // R1 R2 R3: exhaustive sweep of slots, holes and permuted low bits
    for (int k = 0; k < N; k++)
      for (int i = 0; i < 8; i++)
        probe(isHole(k, i) ? "R3" : "R1_R2", k, i, 1'b1);
    // R4: unknown bases miss
    check("R4", {baseV(N), 3'd2}, 1'b0, 28'd0);
    check("R4", {33'd8, 3'd0}, 1'b0, 28'd0);

    // R8: full buffer, victims in order from slot 0
    fill(16);
    fill(17);
    probe("R8", 0, 1, 1'b0);
    probe("R8", 1, 2, 1'b0);
    probe("R8", 2, 3, 1'b1);
    probe("R8", 16, 1, 1'b1);
    probe("R8", 17, 2, 1'b1);

    // R6: overwrite base of k=5 in place, hole filled, new base PPN
    @(negedge clk);
    fillBaseVpn  = baseV(5);
    fillBasePpn  = 25'd99;
    fillSubValid = 8'hFF;
    for (int i = 0; i < 8; i++) fillSubPpn[3*i +: 3] = 3'(7 - i);
    fillEn = 1'b1;
    @(negedge clk);
    fillEn = 1'b0;
    check("R6", {baseV(5), 3'd5}, 1'b1, {25'd99, 3'd2});
    check("R6", {baseV(5), 3'd0}, 1'b1, {25'd99, 3'd7});
    for (int k = 2; k < 18; k++) if (k != 5) probe("R6", k, 0, 1'b1);
    // R6 R8: pointer unmoved by overwrite, next victim is slot 2
    fill(18);
    probe("R8", 2, 3, 1'b0);
    probe("R8", 3, 4, 1'b1);
    probe("R8", 18, 1, 1'b1);

    // R9: flush wins over simultaneous fill
    @(negedge clk);
    drive(20);
    fillEn = 1'b1;
    flush  = 1'b1;
    @(negedge clk);
    fillEn = 1'b0;
    flush  = 1'b0;
    probe("R9", 20, 1, 1'b0);
    probe("R9", 3, 4, 1'b0);
    probe("R9", 18, 1, 1'b0);

    // R7 R9: refill lowest free slots, pointer back at 0
    for (int k = 0; k < N; k++) fill(k);
    for (int k = 0; k < N; k++) probe("R7", k, (k + 1) % 8, 1'b1);
    fill(21);
    probe("R9", 0, 1, 1'b0);
    probe("R9", 1, 2, 1'b1);
    probe("R9", 21, 0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule